// File: doc/BRIEF.md
# Indirect Configuration Access Decoder

This block sits on a host I/O bus and gives software access to the configuration space of the functions attached to a bus through two ports. At the first port the host writes a 32-bit selector word that names the target: the bus, the device slot, the function and a dword register index. The host can also read that word back. At the second port there is a four-byte data window. The host reads or writes one, two or four bytes there, starting at any of the four byte positions.

The decoder checks the held selector word and forwards the access only when the enable bit is set, the bus field is zero and the addressed slot and function are present. A multi-byte access becomes a set of parallel per-byte requests, one lane per byte, toward the configuration storage of the selected function. The byte number of each lane is the dword index times four, plus the low port offset, plus the lane index, and it wraps at 256. Read bytes come back combinationally and are packed into the host read word. A read that misses returns all ones. A write that misses produces no request.

Top module: `cfg_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, the selector word reads as 0x00000000, and every data-window read returns 0xFFFFFFFF with no byte request issued.
- R2: A host write at the selector port (host_addr[2]=0) loads all 32 bits of host_wdata in the next clock edge, whatever the size code. A read at the selector port returns the last value written. With no such write, the word does not change.
- R3: A data access (host_addr[2]=1) is a candidate hit only when selector bit 31 is 1 and selector bits 23:16 are 0x00. Selector bits 30:24 are not checked.
- R4: The byte register number on lane k is ((selector & 0xFC) + host_addr[1:0] + k) modulo 256. It is carried on cfg_req_reg[8k+7:8k].
- R5: On a hit, size code 0 drives lane 0 only, code 1 drives lanes 0–1, and code 2 drives lanes 0–3. Code 3 is illegal: it issues no request and reads as 0xFFFFFFFF. Lane k carries host data bits 8k+7:8k.
- R6: A hit read returns cfg_rdata byte k in host_rdata bits 8k+7:8k for each active lane. The bytes above the active lanes read as zero.
- R7: A data read that is not a hit returns 0xFFFFFFFF.
- R8: A data write that is not a hit issues no byte request.
- R9: The slot is selector bits 15:11 and the function is bits 10:8. Function 0 is present when slot_present[slot] is 1. A function f>0 is present only when slot_present[slot] and func_present[slot*NFUNC+f] are both 1. Slots at or above NSLOT are absent.
- R10: Every byte request carries the selector's slot and function fields and the host read/write flag.
- R11: No byte request is issued when host_valid is 0 or when the access targets the selector port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Bit 2: 0 selector port, 1 data window; bits 1:0 byte offset in the window |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| slot_present | input | NSLOT | Slot populated mask |
| func_present | input | NSLOT*NFUNC | Per-slot extra-function presence mask (bit slot*NFUNC+f) |
| cfg_req_valid | output | 4 | Per-lane byte request valid |
| cfg_req_write | output | 1 | Request direction |
| cfg_req_slot | output | 5 | Target slot |
| cfg_req_func | output | 3 | Target function |
| cfg_req_reg | output | 32 | Byte register number per lane, 8 bits each |
| cfg_req_wdata | output | 32 | Write byte per lane |
| cfg_rdata | input | 32 | Read byte per lane, returned in the same cycle |

## Verification
The random selector words mix the enable bit, zero and non-zero bus fields, and every slot and function against a fixed presence pattern. These words tell the gating conditions apart from each other and from the absent-slot and absent-function cases. Directed cases cover the offset-3 four-byte access whose register numbers wrap past 0xFF, an enabled word with the reserved bits set, and the illegal size code. They also cover the top slot and the function-zero-versus-extra-function rule. The bench answers each read byte with a value that depends on slot, function and register. Any misrouted lane, wrong byte order or missing zero fill therefore shows up in the packed read word.

// File: rtl/cfgw_pkg.sv
// Package: shared types and helpers for the indirect configuration decoder.
// Assumes a 32-bit host data path split into four byte lanes.
package cfgw_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int DATA_W  = BYTE_W * LANES;
    localparam int SLOT_W  = 5;
    localparam int FUNC_W  = 3;
    localparam int MAX_SLOTS = 1 << SLOT_W;
    localparam int MAX_FUNCS = 1 << FUNC_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    // Layout of the selector word held at the selector port
    typedef struct packed {
        logic              enable;
        logic [6:0]        rsvd;
        logic [7:0]        bus;
        logic [SLOT_W-1:0] slot;
        logic [FUNC_W-1:0] func;
        logic [5:0]        dword;
        logic [1:0]        low;
    } sel_word_t;

    // Number of byte lanes a size code touches (0 for the illegal code)
    function automatic logic [2:0] lane_count(xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfgw_sel_latch.sv
// Selector word register. Loads the full word on a load strobe and
// clears to zero on synchronous active-low reset.
module cfgw_sel_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // Hold or replace the selector word
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

endmodule

// File: rtl/cfgw_target_check.sv
// Decides whether the selected bus/slot/function exists and the access is
// enabled. Assumes NSLOT <= 32 and NFUNC <= 8. Function 0 needs only the slot.
module cfgw_target_check
    import cfgw_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NFUNC = 8
) (
    input  logic                   enable,
    input  logic [7:0]             bus,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [FUNC_W-1:0]      func,
    input  xfer_size_e             size,
    input  logic [NSLOT-1:0]       slot_present,
    input  logic [NSLOT*NFUNC-1:0] func_present,
    output logic                   hit
);

    localparam int FLAT = MAX_SLOTS * MAX_FUNCS;

    logic [MAX_SLOTS-1:0] slot_ext;
    logic [FLAT-1:0]      func_ext;

    // Widen the presence masks to the full address space; missing entries are absent
    for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
        if (s < NSLOT) begin : g_on
            assign slot_ext[s] = slot_present[s];
        end else begin : g_off
            assign slot_ext[s] = 1'b0;
        end
        for (genvar f = 0; f < MAX_FUNCS; f++) begin : g_func
            if (s < NSLOT && f < NFUNC && f > 0) begin : g_on
                assign func_ext[s*MAX_FUNCS+f] = func_present[s*NFUNC+f];
            end else begin : g_off
                assign func_ext[s*MAX_FUNCS+f] = 1'b0;
            end
        end
    end

    logic slot_ok;
    logic func_ok;

    // Combine gating, size legality and presence into a single hit
    always_comb begin
        slot_ok = slot_ext[slot];
        func_ok = (func == '0) ? 1'b1 : func_ext[{slot, func}];
        hit     = enable && (bus == 8'h00) && (size != SZ_BAD) && slot_ok && func_ok;
    end

endmodule

// File: rtl/cfgw_lane_split.sv
// Splits one data-window access into per-byte lane requests and packs the
// returned bytes. Register numbers wrap modulo 256 across lanes.
module cfgw_lane_split
    import cfgw_pkg::*;
(
    input  logic                active,
    input  xfer_size_e          size,
    input  logic [5:0]          dword,
    input  logic [1:0]          port_lo,
    input  logic [DATA_W-1:0]   cfg_rdata,
    output logic [LANES-1:0]    req_valid,
    output logic [DATA_W-1:0]   req_reg,
    output logic [DATA_W-1:0]   packed_rdata
);

    logic [2:0]        nbytes;
    logic [BYTE_W-1:0] base_reg;

    // Lane count and starting byte register number
    always_comb begin
        nbytes   = lane_count(size);
        base_reg = {dword, 2'b00} + {6'b0, port_lo};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Per-lane valid, register number and read byte (zero when idle)
        always_comb begin
            req_valid[k]                  = active && (3'(k) < nbytes);
            req_reg[k*BYTE_W +: BYTE_W]   = base_reg + BYTE_W'(k);
            packed_rdata[k*BYTE_W +: BYTE_W] =
                req_valid[k] ? cfg_rdata[k*BYTE_W +: BYTE_W] : '0;
        end
    end

endmodule

// File: rtl/cfg_window_decoder.sv
// Top: selector port plus four-byte data window for indirect configuration
// access. Host read data is combinational; only the selector word is stored.
module cfg_window_decoder
    import cfgw_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NFUNC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_valid,
    input  logic                   host_write,
    input  logic [2:0]             host_addr,
    input  logic [1:0]             host_size,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic [DATA_W-1:0]      host_rdata,
    input  logic [NSLOT-1:0]       slot_present,
    input  logic [NSLOT*NFUNC-1:0] func_present,
    output logic [LANES-1:0]       cfg_req_valid,
    output logic                   cfg_req_write,
    output logic [SLOT_W-1:0]      cfg_req_slot,
    output logic [FUNC_W-1:0]      cfg_req_func,
    output logic [DATA_W-1:0]      cfg_req_reg,
    output logic [DATA_W-1:0]      cfg_req_wdata,
    input  logic [DATA_W-1:0]      cfg_rdata
);

    logic [DATA_W-1:0] sel_q;
    sel_word_t         sel;
    xfer_size_e        size;
    logic              sel_port;
    logic              sel_load;
    logic              hit;
    logic              active;
    logic [DATA_W-1:0] packed_rdata;

    // Port decode and strobes
    always_comb begin
        sel      = sel_word_t'(sel_q);
        size     = xfer_size_e'(host_size);
        sel_port = !host_addr[2];
        sel_load = host_valid && host_write && sel_port;
        active   = host_valid && !sel_port && hit;
    end

    cfgw_sel_latch #(.W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_load),
        .din   (host_wdata),
        .q     (sel_q)
    );

    cfgw_target_check #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u_check (
        .enable       (sel.enable),
        .bus          (sel.bus),
        .slot         (sel.slot),
        .func         (sel.func),
        .size         (size),
        .slot_present (slot_present),
        .func_present (func_present),
        .hit          (hit)
    );

    cfgw_lane_split u_split (
        .active       (active),
        .size         (size),
        .dword        (sel.dword),
        .port_lo      (host_addr[1:0]),
        .cfg_rdata    (cfg_rdata),
        .req_valid    (cfg_req_valid),
        .req_reg      (cfg_req_reg),
        .packed_rdata (packed_rdata)
    );

    // Request fields and host read mux (all ones on a data-window miss)
    always_comb begin
        cfg_req_write = host_write;
        cfg_req_slot  = sel.slot;
        cfg_req_func  = sel.func;
        cfg_req_wdata = host_wdata;
        if (sel_port)
            host_rdata = sel_q;
        else if (hit)
            host_rdata = packed_rdata;
        else
            host_rdata = '1;
    end

endmodule

// File: rtl/cfgw_checker.sv
// Temporal checks on the decoder, attached to every instance by bind.
module cfgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic        host_write,
    input logic [2:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic [31:0] sel_q,
    input logic [3:0]  cfg_req_valid,
    input logic [31:0] cfg_req_reg
);

    // R2: a selector-port write is visible in the next cycle
    p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && !host_addr[2]) |=> (sel_q == $past(host_wdata)));

    // R2: without a selector write the word holds
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && host_write && !host_addr[2]) |=> $stable(sel_q));

    // R3: requests only under enable and bus zero
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_req_valid) |-> (sel_q[31] && sel_q[23:16] == 8'h00));

    // R5: active lanes are a contiguous run from lane 0 of length 1, 2 or 4
    p_lane_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid == 4'h0 || cfg_req_valid == 4'h1 ||
         cfg_req_valid == 4'h3 || cfg_req_valid == 4'hF));

    // R4: lane 0 register number is the dword index joined with the port offset
    p_lane0_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid[0] |-> (cfg_req_reg[7:0] == {sel_q[7:2], host_addr[1:0]}));

    // R7: a data read with no request reads as all ones
    p_miss_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && host_addr[2] && cfg_req_valid == 4'h0)
            |-> (host_rdata == 32'hFFFF_FFFF));

    // R11: selector-port accesses never raise a request
    p_sel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_addr[2]) |-> (cfg_req_valid == 4'h0));

endmodule

bind cfg_window_decoder cfgw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_write    (host_write),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .sel_q         (sel_q),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_reg   (cfg_req_reg)
);

// File: tb/cfg_window_decoder_bench.sv
module cfg_window_decoder_bench;

    localparam int NSLOT = 32;
    localparam int NFUNC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [NSLOT-1:0]       slot_present;
    logic [NSLOT*NFUNC-1:0] func_present;
    logic [3:0]  cfg_req_valid;
    logic        cfg_req_write;
    logic [4:0]  cfg_req_slot;
    logic [2:0]  cfg_req_func;
    logic [31:0] cfg_req_reg;
    logic [31:0] cfg_req_wdata;
    logic [31:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] sel_model = '0;

    always #2 clk = ~clk;

    cfg_window_decoder #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u_cfg_window_decoder (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .slot_present(slot_present), .func_present(func_present),
        .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
        .cfg_req_slot(cfg_req_slot), .cfg_req_func(cfg_req_func),
        .cfg_req_reg(cfg_req_reg), .cfg_req_wdata(cfg_req_wdata), .cfg_rdata(cfg_rdata)
    );

    // Bench config storage: byte value depends on slot, function and register
    function automatic logic [7:0] mdl_byte(logic [4:0] s, logic [2:0] f, logic [7:0] r);
        return r ^ {s, f} ^ 8'h5A;
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++)
            cfg_rdata[k*8 +: 8] = mdl_byte(cfg_req_slot, cfg_req_func, cfg_req_reg[k*8 +: 8]);
    end

    function automatic bit exp_hit(logic [31:0] a, logic [1:0] sz);
        logic [4:0] s;
        logic [2:0] f;
        s = a[15:11];
        f = a[10:8];
        if (!a[31] || a[23:16] != 8'h00 || sz == 2'd3) return 1'b0;
        if (!slot_present[s]) return 1'b0;
        if (f != 3'd0 && !func_present[int'(s)*NFUNC + int'(f)]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_nbytes(logic [1:0] sz);
        case (sz)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg(logic [31:0] a, logic [1:0] lo, int k);
        return 8'((a[7:0] & 8'hFC) + {6'b0, lo} + 8'(k));
    endfunction

    function automatic logic [3:0] exp_valid(logic [31:0] a, logic [1:0] sz);
        if (!exp_hit(a, sz)) return 4'h0;
        return 4'((1 << exp_nbytes(sz)) - 1);
    endfunction

    function automatic logic [31:0] exp_rdata(logic [31:0] a, logic [1:0] lo, logic [1:0] sz);
        logic [31:0] v;
        if (!exp_hit(a, sz)) return 32'hFFFF_FFFF;
        v = '0;
        for (int k = 0; k < exp_nbytes(sz); k++)
            v[k*8 +: 8] = mdl_byte(a[15:11], a[10:8], exp_reg(a, lo, k));
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write the selector word and read it back (R2)
    task automatic set_sel(logic [31:0] v);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = 3'b000;
        host_size = 2'd2; host_wdata = v;
        @(negedge clk);
        sel_model = v;
        host_write = 1'b0; host_wdata = 32'h0;
        #1;
        chk(host_rdata == sel_model, "R2 selector readback", host_rdata, sel_model);
        chk(cfg_req_valid == 4'h0, "R11 selector port no request", {28'h0, cfg_req_valid}, 32'h0);
    endtask

    // One data-window access, checked against the bench model
    task automatic data_acc(logic [1:0] lo, logic [1:0] sz, bit wr, logic [31:0] wd);
        logic [3:0] ev;
        logic [31:0] er;
        int n;
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = {1'b1, lo};
        host_size = sz; host_wdata = wd;
        #1;
        ev = exp_valid(sel_model, sz);
        n  = exp_nbytes(sz);
        if (ev == 4'h0)
            chk(cfg_req_valid == 4'h0, wr ? "R8 write miss discarded" : "R7 read miss no request",
                {28'h0, cfg_req_valid}, 32'h0);
        else
            chk(cfg_req_valid == ev, "R5 lane valids", {28'h0, cfg_req_valid}, {28'h0, ev});
        if (!wr) begin
            er = exp_rdata(sel_model, lo, sz);
            chk(host_rdata == er, (ev == 4'h0) ? "R7 miss reads ones" : "R6 packed read",
                host_rdata, er);
        end
        if (ev != 4'h0) begin
            for (int k = 0; k < n; k++) begin
                chk(cfg_req_reg[k*8 +: 8] == exp_reg(sel_model, lo, k), "R4 lane register",
                    {24'h0, cfg_req_reg[k*8 +: 8]}, {24'h0, exp_reg(sel_model, lo, k)});
                if (wr)
                    chk(cfg_req_wdata[k*8 +: 8] == wd[k*8 +: 8], "R5 write byte lane",
                        {24'h0, cfg_req_wdata[k*8 +: 8]}, {24'h0, wd[k*8 +: 8]});
            end
            chk({cfg_req_slot, cfg_req_func, cfg_req_write} == {sel_model[15:8], wr},
                "R10 request fields", {23'h0, cfg_req_slot, cfg_req_func, cfg_req_write},
                {23'h0, sel_model[15:8], wr});
        end
        host_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd29));
        slot_present = 32'hA000_00F5;
        for (int s = 0; s < NSLOT; s++)
            for (int f = 0; f < NFUNC; f++)
                func_present[s*NFUNC+f] = ((s + f) % 3) != 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        host_valid = 1'b1; host_write = 1'b0; host_addr = 3'b000; host_size = 2'd2;
        #1;
        chk(host_rdata == 32'h0, "R1 selector cleared", host_rdata, 32'h0);
        host_valid = 1'b0;
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        chk(host_rdata == 32'hFFFF_FFFF, "R1 data miss after reset", host_rdata, 32'hFFFF_FFFF);

        // R11: idle bus with a hitting selector
        set_sel(32'h8000_0010);
        @(negedge clk);
        host_valid = 1'b0; host_addr = 3'b100; host_size = 2'd2;
        #1;
        chk(cfg_req_valid == 4'h0, "R11 idle no request", {28'h0, cfg_req_valid}, 32'h0);

        // R4: offset 3, four bytes, register numbers wrap past 0xFF
        set_sel(32'h8000_00FC);
        data_acc(2'd3, 2'd2, 1'b0, 32'h0);
        chk(cfg_req_reg == 32'h0201_00FF, "R4 wrap lanes", cfg_req_reg, 32'h0201_00FF);
        data_acc(2'd2, 2'd1, 1'b1, 32'hCAFE_BEEF);
        data_acc(2'd1, 2'd0, 1'b0, 32'h0);

        // R3: bus non-zero, enable clear, reserved bits ignored
        set_sel(32'h8001_0000);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        set_sel(32'h0000_0004);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        set_sel(32'hFF00_0008);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        chk(cfg_req_valid == 4'hF, "R3 reserved bits ignored", {28'h0, cfg_req_valid}, 32'hF);

        // R5: illegal size code
        data_acc(2'd0, 2'd3, 1'b0, 32'h0);
        data_acc(2'd0, 2'd3, 1'b1, 32'h1234_5678);

        // R9: absent slot, absent and present extra function, top slot
        set_sel(32'h8000_0800);
        data_acc(2'd0, 2'd2, 1'b1, 32'h1111_2222);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        set_sel(32'h8000_0300);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        chk(host_rdata == 32'hFFFF_FFFF, "R9 absent function", host_rdata, 32'hFFFF_FFFF);
        set_sel(32'h8000_0140);
        data_acc(2'd0, 2'd2, 1'b0, 32'h0);
        chk(cfg_req_valid == 4'hF, "R9 present function", {28'h0, cfg_req_valid}, 32'hF);
        set_sel(32'h8000_F83C);
        data_acc(2'd1, 2'd1, 1'b0, 32'h0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            a[31] = ($urandom % 4) != 0;
            if (($urandom % 4) != 0) a[23:16] = 8'h00;
            set_sel(a);
            for (int j = 0; j < 2; j++)
                data_acc(2'($urandom), 2'($urandom), 1'($urandom), $urandom);
        end

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule